// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block turns a single-cycle host write request into a correctly timed write cycle on an asynchronous static RAM. The RAM has active-low chip-enable, read/write and output-enable pins. Each request carries an address, a data word, a strobe mode and the output-enable level to hold during the cycle. The sequencer registers the request, puts the address on the RAM pins and waits out an address setup count with one strobe already low. It then drops the second strobe to open the write window. Afterwards it raises both strobes together, holds the data and waits out write recovery. Finally it pulses `done` for one clock.

Two strobe shapes are supported. In R/W-shaped mode, chip-enable leads and the R/W strobe opens and closes the window. In chip-enable-shaped mode, R/W leads and chip-enable opens and closes the window. In R/W-shaped mode with output-enable held low, the RAM drives its data pins until R/W falls. For that case the window is stretched and the host data is driven only after a turn-off interval. Every interval is a clock-count parameter, so one netlist can serve parts of different speed grades by changing parameters.

Top module: `sram_wr_seq`

## Requirements
- R1: Out of reset and while idle, `ram_ce_n` and `ram_we_n` are 1, `ram_wdata_oe` is 0, `done` is 0, `ram_oe_n` is 1 and `req_ready` is 1.
- R2: A request is taken only when `req_valid` is 1 while `req_ready` is 1. `req_ready` is 0 from the acceptance edge until the block is idle again, and a request raised during that time is ignored: the address, the data and the number of `done` pulses are unchanged.
- R3: The address appears on `ram_addr` on the clock after acceptance. Exactly T_AS clocks later, both strobes are low. `ram_addr` stays unchanged until `done` has been shown.
- R4: With `req_ce_mode`=0 (R/W-shaped), the setup clocks show `ram_ce_n`=0 and `ram_we_n`=1. With `req_ce_mode`=1 (chip-enable-shaped), they show `ram_we_n`=0 and `ram_ce_n`=1. The two strobes never fall on the same clock.
- R5: In chip-enable-shaped mode, or in R/W-shaped mode with `req_oe_n`=1, both strobes are low for exactly T_WP clocks.
- R6: In R/W-shaped mode with `req_oe_n`=0, both strobes are low for max(T_WP, T_WZ+T_DW) clocks. `ram_wdata_oe` rises T_WZ clocks after the window opens, leaving at least T_DW driven clocks before the window closes.
- R7: In every other mode/level combination, `ram_wdata_oe` rises on the same clock on which the window opens.
- R8: `ram_wdata_oe` is never 1 while the RAM may drive its pins, that is while `ram_ce_n`=0, `ram_oe_n`=0 and `ram_we_n`=1.
- R9: Both strobes rise on the same clock at the end of the window. `ram_wdata_oe` stays 1 for exactly T_DH clocks after that and then falls.
- R10: After the strobes rise, they stay high for max(T_DH, T_WR) clocks. Then `done` is 1 for exactly one clock with both strobes high, and on the next clock the block is idle.
- R11: From the clock after acceptance until `done` has been shown, `ram_oe_n` equals the requested `req_oe_n`.
- R12: Whenever `ram_wdata_oe` is 1, `ram_wdata` equals the accepted `req_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_ce_mode | input | 1 | 0 = R/W-shaped window, 1 = chip-enable-shaped window |
| req_oe_n | input | 1 | Output-enable level to hold during the cycle |
| ram_addr | output | AW | RAM address pins |
| ram_ce_n | output | 1 | RAM chip-enable, active low |
| ram_we_n | output | 1 | RAM read/write, low = write |
| ram_oe_n | output | 1 | RAM output-enable, active low |
| ram_wdata | output | DW | Data toward the RAM data pins |
| ram_wdata_oe | output | 1 | Drive enable for `ram_wdata` |
| done | output | 1 | One-clock pulse at the end of the cycle |

## Verification
All results are counted from the acceptance edge, numbered 0, and appear on the clock that follows each edge. The address and the leading strobe are due after edge 0. The window opens after edge T_AS and lasts the mode's pulse length PL. The strobes rise after edge T_AS+PL, and `done` is due after edge T_AS+PL+max(T_DH,T_WR). The bench samples every output on the falling clock edge after each rising edge and stores one record per edge. It then compares indices in that record with these formulas for all four mode and output-enable combinations, so an output that is one clock early or late fails. The drive-start offset and the hold count are checked as exact indices, not as windows.

// File: rtl/sram_wr_seq_pkg.sv
package sram_wr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_RECOV,
      ST_DONE
   } wr_state_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] count,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign count = cnt_q;
   assign zero  = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_dpath.sv
module sram_wr_dpath #(
   parameter int unsigned AW = 11,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          busy,
   input  logic          req_ready,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_ce_mode,
   input  logic          req_oe_n,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   output logic          ram_oe_n,
   output logic          mode_ce,
   output logic          oe_low
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          mode_q;
   logic          oe_n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         mode_q <= 1'b0;
         oe_n_q <= 1'b1;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
         mode_q <= req_ce_mode;
         oe_n_q <= req_oe_n;
      end
   end

   assign ram_addr  = addr_q;
   assign ram_wdata = data_q;
   assign ram_oe_n  = busy ? oe_n_q : 1'b1;
   assign mode_ce   = mode_q;
   assign oe_low    = !oe_n_q;

   // R2: captured request only moves on a handshake
   p_capture_on_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_q != $past(addr_q)) |-> $past(req_ready && req_valid));

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
   import sram_wr_seq_pkg::*;
#(
   parameter int unsigned T_AS = 2,
   parameter int unsigned T_WP = 3,
   parameter int unsigned T_WZ = 2,
   parameter int unsigned T_DW = 2,
   parameter int unsigned T_DH = 1,
   parameter int unsigned T_WR = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mode_ce,
   input  logic oe_low,
   output logic req_ready,
   output logic accept,
   output logic busy,
   output logic ce_n,
   output logic we_n,
   output logic drive_en,
   output logic done
);

   localparam int unsigned PL_OE  = imax(T_WP, T_WZ + T_DW);
   localparam int unsigned RL     = imax(T_DH, T_WR);
   localparam int unsigned MAXLEN = imax(imax(T_AS, PL_OE), RL);
   localparam int unsigned CW     = $clog2(MAXLEN + 1);

   generate
      if (T_AS < 1 || T_WP < 1 || T_WZ < 1 || T_DW < 1 || T_DH < 1 || T_WR < 1) begin : g_bad_timing
         $error("sram_wr_fsm: every interval must be at least one clock");
      end
   endgenerate

   wr_state_e     state_q, state_d;
   logic          t_load;
   logic [CW-1:0] t_val;
   logic [CW-1:0] t_cnt;
   logic          t_zero;
   logic [CW-1:0] pulse_last;
   logic          off_wait;

   sram_wr_timer #(.CW(CW)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .count    (t_cnt),
      .zero     (t_zero)
   );

   assign off_wait = !mode_ce && oe_low;

   generate
      if (T_WZ + T_DW > T_WP) begin : g_stretch
         assign pulse_last = off_wait ? CW'(PL_OE - 1) : CW'(T_WP - 1);
      end else begin : g_flat
         assign pulse_last = CW'(T_WP - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) begin
            state_d = ST_SETUP;
            t_load  = 1'b1;
            t_val   = CW'(T_AS - 1);
         end
         ST_SETUP: if (t_zero) begin
            state_d = ST_PULSE;
            t_load  = 1'b1;
            t_val   = pulse_last;
         end
         ST_PULSE: if (t_zero) begin
            state_d = ST_RECOV;
            t_load  = 1'b1;
            t_val   = CW'(RL - 1);
         end
         ST_RECOV: if (t_zero) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign busy      = !req_ready;
   assign done      = (state_q == ST_DONE);

   always_comb begin
      ce_n     = 1'b1;
      we_n     = 1'b1;
      drive_en = 1'b0;
      unique case (state_q)
         ST_SETUP: begin
            ce_n = mode_ce;
            we_n = !mode_ce;
         end
         ST_PULSE: begin
            ce_n     = 1'b0;
            we_n     = 1'b0;
            drive_en = !off_wait ||
                       (({1'b0, t_cnt} + (CW+1)'(T_WZ)) <= {1'b0, pulse_last});
         end
         ST_RECOV: drive_en = (t_cnt >= CW'(RL - T_DH));
         default: ;
      endcase
   end

   // R10: completion pulse lasts a single clock
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: completion is followed by idle
   p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
   parameter int unsigned AW   = 11,
   parameter int unsigned DW   = 8,
   parameter int unsigned T_AS = 2,
   parameter int unsigned T_WP = 3,
   parameter int unsigned T_WZ = 2,
   parameter int unsigned T_DW = 2,
   parameter int unsigned T_DH = 1,
   parameter int unsigned T_WR = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_ce_mode,
   input  logic          req_oe_n,
   output logic [AW-1:0] ram_addr,
   output logic          ram_ce_n,
   output logic          ram_we_n,
   output logic          ram_oe_n,
   output logic [DW-1:0] ram_wdata,
   output logic          ram_wdata_oe,
   output logic          done
);

   logic accept;
   logic busy;
   logic mode_ce;
   logic oe_low;

   sram_wr_dpath #(.AW(AW), .DW(DW)) dpath_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .busy        (busy),
      .req_ready   (req_ready),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_data    (req_data),
      .req_ce_mode (req_ce_mode),
      .req_oe_n    (req_oe_n),
      .ram_addr    (ram_addr),
      .ram_wdata   (ram_wdata),
      .ram_oe_n    (ram_oe_n),
      .mode_ce     (mode_ce),
      .oe_low      (oe_low)
   );

   sram_wr_fsm #(
      .T_AS (T_AS), .T_WP (T_WP), .T_WZ (T_WZ),
      .T_DW (T_DW), .T_DH (T_DH), .T_WR (T_WR)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .mode_ce   (mode_ce),
      .oe_low    (oe_low),
      .req_ready (req_ready),
      .accept    (accept),
      .busy      (busy),
      .ce_n      (ram_ce_n),
      .we_n      (ram_we_n),
      .drive_en  (ram_wdata_oe),
      .done      (done)
   );

   // R3: address frozen while the write window is open
   p_addr_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_ce_n && !ram_we_n) |-> $stable(ram_addr));
   // R4: exactly one strobe was low just before the window opened
   p_one_strobe_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_ce_n && !ram_we_n && $past(ram_ce_n || ram_we_n)) |->
         $past(ram_ce_n != ram_we_n));
   // R8: no drive while the RAM could be driving
   p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wdata_oe |-> (ram_ce_n || ram_oe_n || !ram_we_n));
   // R9: strobes close together
   p_close_together_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> $rose(ram_ce_n));
   // R10: completion only with both strobes high
   p_done_strobes_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ram_ce_n && ram_we_n && !ram_wdata_oe));

endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int P_AS = 2;
   localparam int P_WP = 3;
   localparam int P_WZ = 2;
   localparam int P_DW = 2;
   localparam int P_DH = 1;
   localparam int P_WR = 2;
   localparam int RL = (P_DH > P_WR) ? P_DH : P_WR;
   localparam int NS = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_ce_mode = 1'b0;
   logic          req_oe_n = 1'b1;
   logic [AW-1:0] ram_addr;
   logic          ram_ce_n, ram_we_n, ram_oe_n, ram_wdata_oe, done;
   logic [DW-1:0] ram_wdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [AW-1:0] s_addr [NS];
   logic [DW-1:0] s_data [NS];
   logic          s_ce [NS];
   logic          s_we [NS];
   logic          s_oe [NS];
   logic          s_drv [NS];
   logic          s_done [NS];
   logic          s_rdy [NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_wr_seq #(
      .AW(AW), .DW(DW), .T_AS(P_AS), .T_WP(P_WP), .T_WZ(P_WZ),
      .T_DW(P_DW), .T_DH(P_DH), .T_WR(P_WR)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_ce_mode(req_ce_mode),
      .req_oe_n(req_oe_n), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
      .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_wdata(ram_wdata),
      .ram_wdata_oe(ram_wdata_oe), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      chk(ram_ce_n === 1'b1, req, "idle ce_n", int'(ram_ce_n), 1);
      chk(ram_we_n === 1'b1, req, "idle we_n", int'(ram_we_n), 1);
      chk(ram_wdata_oe === 1'b0, req, "idle drive", int'(ram_wdata_oe), 0);
      chk(done === 1'b0, req, "idle done", int'(done), 0);
      chk(ram_oe_n === 1'b1, req, "idle oe_n", int'(ram_oe_n), 1);
      chk(req_ready === 1'b1, req, "idle ready", int'(req_ready), 1);
   endtask

   // One write; records one sample per rising edge, then checks against timing formulas.
   task automatic run_write(input bit mode, input bit oe_n, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input bit inject);
      int pl, off, first_low, nlow, first_drv, ndrv, ndone, done_idx, hold;
      @(negedge clk);
      req_addr = a; req_data = d; req_ce_mode = mode; req_oe_n = oe_n;
      req_valid = 1'b1;
      for (int j = 0; j < NS; j++) begin
         @(negedge clk);
         if (j == 0) req_valid = 1'b0;
         s_addr[j] = ram_addr; s_data[j] = ram_wdata; s_ce[j] = ram_ce_n;
         s_we[j] = ram_we_n; s_oe[j] = ram_oe_n; s_drv[j] = ram_wdata_oe;
         s_done[j] = done; s_rdy[j] = req_ready;
         if (inject && j == P_AS) begin
            req_valid = 1'b1; req_addr = ~a; req_data = ~d;
            req_ce_mode = ~mode; req_oe_n = ~oe_n;
         end else if (inject && j == P_AS + 1) begin
            req_valid = 1'b0;
         end
      end
      off = (!mode && !oe_n) ? P_WZ : 0;
      pl  = (!mode && !oe_n && (P_WZ + P_DW > P_WP)) ? (P_WZ + P_DW) : P_WP;
      done_idx = P_AS + pl + RL;
      first_low = -1; nlow = 0; first_drv = -1; ndrv = 0; ndone = 0; hold = 0;
      for (int j = 0; j < NS; j++) begin
         if (!s_ce[j] && !s_we[j]) begin
            nlow++;
            if (first_low < 0) first_low = j;
         end
         if (s_drv[j]) begin
            ndrv++;
            if (first_drv < 0) first_drv = j;
            if (s_ce[j] && s_we[j]) hold++;
            chk(s_data[j] == d, "R12", "driven data", int'(s_data[j]), int'(d));
         end
         if (s_done[j]) ndone++;
         if (s_drv[j] && !s_ce[j] && !s_oe[j] && s_we[j])
            chk(1'b0, "R8", "drive during RAM read", j, -1);
      end
      // R4: leading strobe during setup
      chk(s_ce[0] == mode && s_we[0] == !mode, "R4", "setup ce_n/we_n",
          int'({s_ce[0], s_we[0]}), int'({mode, !mode}));
      // R3: setup count and address stability
      chk(first_low == P_AS, "R3", "window open index", first_low, P_AS);
      for (int j = 0; j <= done_idx && j < NS; j++)
         chk(s_addr[j] == a, "R3", "address held", int'(s_addr[j]), int'(a));
      // R5 / R6: window length
      chk(nlow == pl, (!mode && !oe_n) ? "R6" : "R5", "window length", nlow, pl);
      // R6 / R7: drive start
      chk(first_drv == P_AS + off, (off != 0) ? "R6" : "R7", "drive start",
          first_drv, P_AS + off);
      chk((pl - off) >= P_DW, "R6", "data setup clocks", pl - off, P_DW);
      // R9: both rise together, hold count
      chk(s_ce[P_AS + pl] && s_we[P_AS + pl], "R9", "strobes rise together",
          int'({s_ce[P_AS + pl], s_we[P_AS + pl]}), 3);
      chk(hold == P_DH, "R9", "hold clocks", hold, P_DH);
      chk(ndrv == pl - off + P_DH, "R9", "total drive clocks", ndrv, pl - off + P_DH);
      // R10: done position and count, then idle
      chk(s_done[done_idx] === 1'b1, "R10", "done index", int'(s_done[done_idx]), 1);
      chk(ndone == 1, "R10", "done pulses", ndone, 1);
      chk(s_rdy[done_idx + 1] && s_ce[done_idx + 1] && s_we[done_idx + 1], "R10",
          "idle after done", int'({s_rdy[done_idx + 1], s_ce[done_idx + 1],
          s_we[done_idx + 1]}), 7);
      // R2: not ready while busy
      for (int j = 0; j <= done_idx; j++)
         chk(!s_rdy[j], "R2", "ready while busy", int'(s_rdy[j]), 0);
      // R11: output-enable follows request
      for (int j = 0; j <= done_idx; j++)
         chk(s_oe[j] == oe_n, "R11", "oe_n level", int'(s_oe[j]), int'(oe_n));
      if (inject) begin
         // R2: injected request ignored; nothing starts afterwards
         for (int j = done_idx + 1; j < NS; j++)
            chk(s_ce[j] && s_we[j], "R2", "no second cycle",
                int'({s_ce[j], s_we[j]}), 3);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      run_write(1'b0, 1'b0, 11'h5A3, 8'hC7, 1'b0);  // R/W-shaped, OE low
      run_write(1'b0, 1'b1, 11'h0F1, 8'h3C, 1'b0);  // R/W-shaped, OE high
      run_write(1'b1, 1'b0, 11'h7FF, 8'hA5, 1'b0);  // chip-enable-shaped, OE low
      run_write(1'b1, 1'b1, 11'h000, 8'hFF, 1'b0);  // chip-enable-shaped, OE high
      run_write(1'b0, 1'b0, 11'h2B4, 8'h69, 1'b1);  // busy request ignored
      run_write(1'b1, 1'b0, 11'h401, 8'h00, 1'b1);
      @(negedge clk);
      check_idle("R1");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule